// File: doc/BRIEF.md
# Region-Based Virtual Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address. Pages are 512 bytes, so the low nine address bits pass through unchanged. The two top address bits choose a region. Two per-process regions share the lower half of the space: a program region that grows up from zero and a stack region that grows down toward the middle. The shared system region occupies the upper half. Each region has its own single-level page table, described by a base and a length. The system table sits at a physical address. The two process tables sit at system-virtual addresses, so a process lookup first maps the page-table-entry address through the system table and only then reads the entry it needs.

The CPU side gives the block one request at a time. The answer comes back as a single-cycle response that carries either a physical address or a fault code. Page-table entries are fetched over a plain read port: the block issues a one-cycle read strobe with an address, and the memory later returns one data word with a valid pulse.

Top module: `rgn_xlate`

## Requirements
- R1: While reset is held and right after it, `rsp_valid` and `mem_rd_en` are 0 and `req_ready` is 1.
- R2: Address bits 31:30 choose the region: 00 program, 01 stack, 10 system. Value 11 answers with code 1 in the cycle after acceptance and issues no memory read.
- R3: A system-region request reads the entry at `sys_base + 4*vpn`, where vpn is bits 29:9. If entry bit 31 is 1, the response gives `{entry[20:0], va[8:0]}` with code 0 in the cycle after the data returns.
- R4: A program-region request whose vpn is at or above `p0_len` answers with code 2 in the cycle after acceptance. vpn = `p0_len-1` translates.
- R5: A stack-region request whose vpn is below `p1_len` answers with code 2. vpn equal to `p1_len` translates.
- R6: A system-region request whose vpn is at or above `sys_len` answers with code 2 and issues no read.
- R7: A process request forms the entry address base + 4*vpn in system space and reads the system entry for it. It then reads the process entry at `{sysentry[20:0], entryaddr[8:0]}` and answers `{entry[20:0], va[8:0]}` with code 0. Each translation issues exactly two reads.
- R8: If the process entry address is outside the system region, or its system vpn is at or above `sys_len`, the response is code 3 and no read is issued.
- R9: If the system entry that maps a process table has bit 31 at 0, the response is code 4 and the second read is skipped.
- R10: If the final entry has bit 31 at 0, in either a system or a process lookup, the response is code 5 with `rsp_fault` set.
- R11: `rsp_valid` lasts exactly one cycle. `req_ready` stays 0 from acceptance through the response cycle. `mem_rd_en` is a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block idle and accepting a request |
| sys_base | input | 30 | Physical base of the system page table |
| sys_len | input | 21 | Number of system page entries |
| p0_base | input | 32 | System-virtual base of the program-region table |
| p0_len | input | 21 | Number of program-region page entries |
| p1_base | input | 32 | System-virtual base of the stack-region table |
| p1_len | input | 21 | Lowest valid stack-region page number |
| mem_rd_en | output | 1 | One-cycle entry read strobe |
| mem_rd_addr | output | 30 | Physical address of the entry to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned entry; bit 31 valid, bits 20:0 frame |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 3 | 0 ok, 1 region, 2 length, 3 map address, 4 map entry invalid, 5 entry invalid |
| rsp_pa | output | 30 | Translated physical address, 0 on fault |

## Verification
Faults that depend only on the request (codes 1, 2 and 3) answer in the first cycle after the accepting edge. Every other result answers in the cycle after the last returned entry. The bench memory returns data on the second edge after a strobe. That puts system lookups and map faults 4 cycles after acceptance, and two-read process lookups 7 cycles after it. Each scenario task counts falling edges from acceptance until `rsp_valid` and compares that count with the exact figure. It counts the read strobes the translation issued and checks that the pulse has gone one cycle later.

// File: rtl/rgn_xlate_pkg.sv
package rgn_xlate_pkg;

   typedef enum logic [1:0] {
      RG_P0   = 2'd0,
      RG_P1   = 2'd1,
      RG_SYS  = 2'd2,
      RG_RSVD = 2'd3
   } region_e;

   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_REGION  = 3'd1,
      FC_LENGTH  = 3'd2,
      FC_MAP_LEN = 3'd3,
      FC_MAP_INV = 3'd4,
      FC_PTE_INV = 3'd5
   } fcode_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SYS_RD  = 2'd1,
      ST_PROC_RD = 2'd2,
      ST_RESPOND = 2'd3
   } state_e;

endpackage

// File: rtl/rgn_limit.sv
// Page-number bound check; the direction is chosen at elaboration.
module rgn_limit #(
   parameter int VPN_W     = 21,
   parameter bit GROW_DOWN = 1'b0
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [VPN_W-1:0] len,
   output logic             fault
);
   generate
      if (GROW_DOWN) begin : g_down
         assign fault = (vpn < len);
      end else begin : g_up
         assign fault = (vpn >= len);
      end
   endgenerate
endmodule

// File: rtl/rgn_sysmap.sv
// Looks up a system-virtual address: range check and entry location.
module rgn_sysmap #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 30,
   parameter int OFS_W = 9
) (
   input  logic [VA_W-1:0]         sva,
   input  logic [PA_W-1:0]         sys_base,
   input  logic [VA_W-OFS_W-3:0]   sys_len,
   output logic                    ok,
   output logic [PA_W-1:0]         pte_pa
);
   localparam int VPN_W = VA_W - 2 - OFS_W;

   logic [VPN_W-1:0] svpn;
   logic             len_bad;
   logic             in_sys;
   logic             unused_low;

   assign svpn       = sva[VA_W-3:OFS_W];
   assign in_sys     = (sva[VA_W-1 -: 2] == 2'b10);
   assign unused_low = ^sva[OFS_W-1:0];

   rgn_limit #(.VPN_W(VPN_W), .GROW_DOWN(1'b0)) u_len (
      .vpn   (svpn),
      .len   (sys_len),
      .fault (len_bad)
   );

   assign ok     = in_sys && !len_bad;
   assign pte_pa = sys_base + {{(PA_W-VPN_W-2){1'b0}}, svpn, 2'b00};
endmodule

// File: rtl/rgn_xlate_fsm.sv
// Sequencer: accepts a decoded request, issues entry reads, forms response.
module rgn_xlate_fsm
   import rgn_xlate_pkg::*;
#(
   parameter int PA_W  = 30,
   parameter int OFS_W = 9,
   parameter int PTE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  region_e          region,
   input  logic             len_fault,
   input  logic             map_ok,
   input  logic [PA_W-1:0]  map_pte_pa,
   input  logic [OFS_W-1:0] ofs_req,
   input  logic [OFS_W-1:0] ofs_pte,
   output logic             mem_rd_en,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rd_valid,
   input  logic [PTE_W-1:0] mem_rd_data,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [2:0]       rsp_code,
   output logic [PA_W-1:0]  rsp_pa
);
   localparam int PFN_W = PA_W - OFS_W;

   state_e           state;
   logic             direct_q;
   logic [OFS_W-1:0] ofs_q;
   logic [OFS_W-1:0] pte_ofs_q;
   logic             rd_en_q;
   logic [PA_W-1:0]  rd_addr_q;
   logic             fault_q;
   fcode_e           code_q;
   logic [PA_W-1:0]  pa_q;
   logic             pte_ok;
   logic [PFN_W-1:0] pte_pfn;
   logic             unused_pte;

   assign pte_ok     = mem_rd_data[PTE_W-1];
   assign pte_pfn    = mem_rd_data[PFN_W-1:0];
   assign unused_pte = ^mem_rd_data[PTE_W-2:PFN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         direct_q  <= 1'b0;
         ofs_q     <= '0;
         pte_ofs_q <= '0;
         rd_en_q   <= 1'b0;
         rd_addr_q <= '0;
         fault_q   <= 1'b0;
         code_q    <= FC_NONE;
         pa_q      <= '0;
      end else begin
         rd_en_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  ofs_q     <= ofs_req;
                  pte_ofs_q <= ofs_pte;
                  pa_q      <= '0;
                  if (region == RG_RSVD) begin
                     fault_q <= 1'b1;
                     code_q  <= FC_REGION;
                     state   <= ST_RESPOND;
                  end else if (len_fault) begin
                     fault_q <= 1'b1;
                     code_q  <= FC_LENGTH;
                     state   <= ST_RESPOND;
                  end else if (!map_ok) begin
                     fault_q <= 1'b1;
                     code_q  <= FC_MAP_LEN;
                     state   <= ST_RESPOND;
                  end else begin
                     direct_q  <= (region == RG_SYS);
                     rd_en_q   <= 1'b1;
                     rd_addr_q <= map_pte_pa;
                     state     <= ST_SYS_RD;
                  end
               end
            end
            ST_SYS_RD: begin
               if (mem_rd_valid) begin
                  if (!pte_ok) begin
                     fault_q <= 1'b1;
                     code_q  <= direct_q ? FC_PTE_INV : FC_MAP_INV;
                     state   <= ST_RESPOND;
                  end else if (direct_q) begin
                     fault_q <= 1'b0;
                     code_q  <= FC_NONE;
                     pa_q    <= {pte_pfn, ofs_q};
                     state   <= ST_RESPOND;
                  end else begin
                     rd_en_q   <= 1'b1;
                     rd_addr_q <= {pte_pfn, pte_ofs_q};
                     state     <= ST_PROC_RD;
                  end
               end
            end
            ST_PROC_RD: begin
               if (mem_rd_valid) begin
                  if (!pte_ok) begin
                     fault_q <= 1'b1;
                     code_q  <= FC_PTE_INV;
                  end else begin
                     fault_q <= 1'b0;
                     code_q  <= FC_NONE;
                     pa_q    <= {pte_pfn, ofs_q};
                  end
                  state <= ST_RESPOND;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state == ST_IDLE);
   assign rsp_valid   = (state == ST_RESPOND);
   assign rsp_fault   = fault_q;
   assign rsp_code    = code_q;
   assign rsp_pa      = pa_q;
   assign mem_rd_en   = rd_en_q;
   assign mem_rd_addr = rd_addr_q;

   // R11
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R11
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R11
   rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R2
   rsvd_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && region == RG_RSVD)
         |=> (rsp_valid && rsp_code == 3'd1 && !mem_rd_en));

   // R10
   final_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROC_RD && mem_rd_valid && !mem_rd_data[PTE_W-1])
         |=> (rsp_valid && rsp_fault && rsp_code == 3'd5));

   // R3
   sys_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SYS_RD && direct_q && mem_rd_valid && mem_rd_data[PTE_W-1])
         |=> (rsp_valid && !rsp_fault && rsp_pa[PA_W-1:OFS_W] == $past(mem_rd_data[PFN_W-1:0])));
endmodule

// File: rtl/rgn_xlate.sv
// Top: region decode, per-region bound checks, system-space lookup, sequencer.
module rgn_xlate
   import rgn_xlate_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 30,
   parameter int OFS_W = 9,
   parameter int PTE_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_va,
   output logic                  req_ready,
   input  logic [PA_W-1:0]       sys_base,
   input  logic [VA_W-OFS_W-3:0] sys_len,
   input  logic [VA_W-1:0]       p0_base,
   input  logic [VA_W-OFS_W-3:0] p0_len,
   input  logic [VA_W-1:0]       p1_base,
   input  logic [VA_W-OFS_W-3:0] p1_len,
   output logic                  mem_rd_en,
   output logic [PA_W-1:0]       mem_rd_addr,
   input  logic                  mem_rd_valid,
   input  logic [PTE_W-1:0]      mem_rd_data,
   output logic                  rsp_valid,
   output logic                  rsp_fault,
   output logic [2:0]            rsp_code,
   output logic [PA_W-1:0]       rsp_pa
);
   localparam int VPN_W = VA_W - 2 - OFS_W;
   localparam int PFN_W = PA_W - OFS_W;
   localparam int N_RGN = 3;

   generate
      if (PA_W <= VPN_W + 2) begin : g_bad_pa
         $error("PA_W too small to hold a system table offset");
      end
      if (PFN_W >= PTE_W) begin : g_bad_pte
         $error("frame field overlaps the entry valid bit");
      end
      if (OFS_W < 2) begin : g_bad_ofs
         $error("page offset narrower than an entry");
      end
   endgenerate

   region_e          region;
   logic [VPN_W-1:0] vpn;
   logic [VPN_W-1:0] rgn_len [N_RGN];
   logic [N_RGN-1:0] lim_fault;
   logic             len_fault;
   logic [VA_W-1:0]  proc_base;
   logic [VA_W-1:0]  pte_va;
   logic [VA_W-1:0]  map_va;
   logic             map_ok;
   logic [PA_W-1:0]  map_pte_pa;

   assign region     = region_e'(req_va[VA_W-1 -: 2]);
   assign vpn        = req_va[VA_W-3:OFS_W];
   assign rgn_len[0] = p0_len;
   assign rgn_len[1] = p1_len;
   assign rgn_len[2] = sys_len;

   // Region 1 (stack) grows downward, the others upward.
   generate
      for (genvar g = 0; g < N_RGN; g++) begin : g_lim
         rgn_limit #(.VPN_W(VPN_W), .GROW_DOWN(g == 1)) u_lim (
            .vpn   (vpn),
            .len   (rgn_len[g]),
            .fault (lim_fault[g])
         );
      end
   endgenerate

   always_comb begin
      case (region)
         RG_P0:   len_fault = lim_fault[0];
         RG_P1:   len_fault = lim_fault[1];
         RG_SYS:  len_fault = lim_fault[2];
         default: len_fault = 1'b0;
      endcase
   end

   assign proc_base = (region == RG_P1) ? p1_base : p0_base;
   assign pte_va    = proc_base + {{(VA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
   assign map_va    = (region == RG_SYS) ? req_va : pte_va;

   rgn_sysmap #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_map (
      .sva      (map_va),
      .sys_base (sys_base),
      .sys_len  (sys_len),
      .ok       (map_ok),
      .pte_pa   (map_pte_pa)
   );

   rgn_xlate_fsm #(.PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .region       (region),
      .len_fault    (len_fault),
      .map_ok       (map_ok),
      .map_pte_pa   (map_pte_pa),
      .ofs_req      (req_va[OFS_W-1:0]),
      .ofs_pte      (pte_va[OFS_W-1:0]),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .rsp_valid    (rsp_valid),
      .rsp_fault    (rsp_fault),
      .rsp_code     (rsp_code),
      .rsp_pa       (rsp_pa)
   );

   // R4
   p0_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && region == RG_P0 && vpn >= p0_len)
         |=> (rsp_valid && rsp_code == 3'd2));

   // R5
   p1_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && region == RG_P1 && vpn < p1_len)
         |=> (rsp_valid && rsp_code == 3'd2));
endmodule

// File: tb/tb_rgn_xlate.sv
module tb_rgn_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready;
   logic [29:0] sys_base = '0;
   logic [20:0] sys_len = 21'd16;
   logic [31:0] p0_base = 32'h8000_0200;
   logic [20:0] p0_len = 21'd32;
   logic [31:0] p1_base = 32'h7F80_0440;
   logic [20:0] p1_len = 21'h1F_FFF0;
   logic        mem_rd_en;
   logic [29:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        rsp_valid, rsp_fault;
   logic [2:0]  rsp_code;
   logic [29:0] rsp_pa;

   int CHECKS = 0;
   int ERRORS = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rgn_xlate dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_ready(req_ready), .sys_base(sys_base), .sys_len(sys_len),
      .p0_base(p0_base), .p0_len(p0_len), .p1_base(p1_base), .p1_len(p1_len),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
      .rsp_pa(rsp_pa)
   );

   // Memory model: data returns on the second edge after a strobe.
   logic [31:0] mem [0:4095];
   logic        pend = 1'b0;
   logic [29:0] pend_addr = '0;
   int          nreads = 0;
   logic [29:0] rd_log [0:255];

   always @(posedge clk) begin
      mem_rd_valid <= 1'b0;
      pend         <= mem_rd_en;
      pend_addr    <= mem_rd_addr;
      if (pend) begin
         mem_rd_valid <= 1'b1;
         mem_rd_data  <= mem[pend_addr[13:2]];
      end
      if (mem_rd_en) begin
         rd_log[nreads[7:0]] <= mem_rd_addr;
         nreads <= nreads + 1;
      end
   end

   function automatic logic [31:0] pte(input bit v, input logic [20:0] pfn);
      return {v, 10'd0, pfn};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      CHECKS++;
      if (!ok) begin
         ERRORS++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One translation; latency counted in falling edges after acceptance.
   task automatic xlate(input string req, input logic [31:0] va,
                        input logic exp_fault, input logic [2:0] exp_code,
                        input logic [29:0] exp_pa, input int exp_lat,
                        input int exp_reads, input bit chk_a0,
                        input logic [29:0] exp_a0);
      int lat;
      int n0;
      @(negedge clk);
      chk(req_ready == 1'b1, req, "ready before request", 64'(req_ready), 64'd1);
      n0 = nreads;
      req_valid = 1'b1;
      req_va    = va;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
      chk(rsp_fault == exp_fault, req, "fault flag", 64'(rsp_fault), 64'(exp_fault));
      chk(rsp_code == exp_code, req, "code", 64'(rsp_code), 64'(exp_code));
      chk(rsp_pa == exp_pa, req, "physical address", 64'(rsp_pa), 64'(exp_pa));
      chk(req_ready == 1'b0, "R11", "ready in response cycle", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11", "response pulse width", 64'(rsp_valid), 64'd0);
      chk(nreads - n0 == exp_reads, req, "read count", 64'(nreads - n0), 64'(exp_reads));
      if (chk_a0)
         chk(rd_log[n0[7:0]] == exp_a0, req, "first entry address",
             64'(rd_log[n0[7:0]]), 64'(exp_a0));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
      chk(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset", 64'(mem_rd_en), 64'd0);
      chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R1", "idle after reset",
          64'({rsp_valid, mem_rd_en}), 64'd0);
   endtask

   task automatic t_region;
      xlate("R2", 32'hC000_0000, 1'b1, 3'd1, 30'd0, 1, 0, 1'b0, '0);
      xlate("R2", 32'hFFFF_FFFF, 1'b1, 3'd1, 30'd0, 1, 0, 1'b0, '0);
   endtask

   task automatic t_system;
      xlate("R3", 32'h8000_0123, 1'b0, 3'd0, 30'h0000_4123, 4, 1, 1'b1, 30'h0);
      xlate("R3", 32'h8000_09FF, 1'b0, 3'd0, 30'h0000_25FF, 4, 1, 1'b1, 30'h10);
      xlate("R6", 32'h8000_1FFF, 1'b0, 3'd0, 30'h0000_EFFF, 4, 1, 1'b1, 30'h3C);
      xlate("R6", 32'h8000_2000, 1'b1, 3'd2, 30'd0, 1, 0, 1'b0, '0);
   endtask

   task automatic t_p0;
      xlate("R7", 32'h0000_0045, 1'b0, 3'd0, 30'h0357_9A45, 7, 2, 1'b1, 30'h4);
      xlate("R7", 32'h0000_0BFF, 1'b0, 3'd0, 30'h0002_47FF, 7, 2, 1'b1, 30'h4);
      xlate("R4", 32'h0000_3E10, 1'b0, 3'd0, 30'h0000_6210, 7, 2, 1'b0, '0);
      xlate("R4", 32'h0000_4000, 1'b1, 3'd2, 30'd0, 1, 0, 1'b0, '0);
   endtask

   task automatic t_p1;
      xlate("R7", 32'h7FFF_FE10, 1'b0, 3'd0, 30'h0157_9A10, 7, 2, 1'b1, 30'h8);
      xlate("R5", 32'h7FFF_E000, 1'b0, 3'd0, 30'h0000_8400, 7, 2, 1'b1, 30'h8);
      xlate("R5", 32'h7FFF_DE00, 1'b1, 3'd2, 30'd0, 1, 0, 1'b0, '0);
   endtask

   task automatic t_map_faults;
      p0_base = 32'h0000_1000;
      xlate("R8", 32'h0000_0000, 1'b1, 3'd3, 30'd0, 1, 0, 1'b0, '0);
      p0_base = 32'h8000_2000;
      xlate("R8", 32'h0000_0000, 1'b1, 3'd3, 30'd0, 1, 0, 1'b0, '0);
      p0_base = 32'h8000_0600;
      xlate("R9", 32'h0000_0000, 1'b1, 3'd4, 30'd0, 4, 1, 1'b1, 30'hC);
      p0_base = 32'h8000_0200;
   endtask

   task automatic t_invalid;
      xlate("R10", 32'h0000_0E00, 1'b1, 3'd5, 30'd0, 7, 2, 1'b0, '0);
      xlate("R10", 32'h8000_0600, 1'b1, 3'd5, 30'd0, 4, 1, 1'b1, 30'hC);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
      mem[0]  = pte(1'b1, 21'h20);
      mem[1]  = pte(1'b1, 21'h08);
      mem[2]  = pte(1'b1, 21'h09);
      mem[3]  = pte(1'b0, 21'h0A);
      mem[4]  = pte(1'b1, 21'h12);
      mem[15] = pte(1'b1, 21'h77);
      mem[12'h400] = pte(1'b1, 21'h1ABCD);
      mem[12'h405] = pte(1'b1, 21'h00123);
      mem[12'h407] = pte(1'b0, 21'h00055);
      mem[12'h41F] = pte(1'b1, 21'h00031);
      mem[12'h480] = pte(1'b1, 21'h00042);
      mem[12'h48F] = pte(1'b1, 21'h0ABCD);

      t_reset();
      t_region();
      t_system();
      t_p0();
      t_p1();
      t_map_faults();
      t_invalid();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", CHECKS, ERRORS);
      $finish;
   end

   initial begin
      #(20ns * 100000);
      if (!done) begin
         CHECKS++;
         ERRORS++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", CHECKS, ERRORS);
         $finish;
      end
   end
endmodule